// File: doc/BRIEF.md
# Prescaled Interval Counter with Three Match Comparators

This block is a single 16-bit timer channel. It advances on every system clock, or once per prescaled period when the prescaler is turned on. It counts up or down. It can run freely over the whole 16-bit range, or wrap at a programmable interval value. A separate register file holds the two control fields, the interval value and the three match values, and keeps them stable. The block reads them directly.

On every counter step the block compares the new count against three match values. It emits one-clock event pulses for an interval wrap, a free-running overflow and each match hit. These pulses line up with the clock in which the count shows the new value. An interrupt controller outside the block collects them.

Top module: `pit_match_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `count` is 0 and every event output is low.
- R2: When control bit 0 (disable) is 1, `count` holds its value and no event output pulses.
- R3: When control bit 2 is 0 the counter counts up, one step per tick. With control bit 1 (interval mode) set, the tick after `intervalVal` loads 0, so the period is `intervalVal`+1. With bit 1 clear, it wraps from 0xFFFF to 0.
- R4: When control bit 2 is 1 the counter counts down. A tick at 0 reloads `intervalVal` in interval mode, or 0xFFFF in free-running mode.
- R5: Every wrap or reload raises a one-cycle pulse in the same cycle as the updated count. The pulse is on `evInterval` in interval mode and on `evOverflow` in free-running mode, and the two never pulse together.
- R6: `evMatch[i]` pulses for one cycle when a tick moves the count onto match value i (bits 16i+15:16i of `matchVal`). This happens only while control bit 3 (match enable) is 1. A match value above the active range never fires.
- R7: Control bit 4 (clear) forces `count` to 0 on the next edge. It takes priority over counting and raises no event.
- R8: Clock-control bit 0 enables the prescaler. With it set, the 4-bit field N in clock-control bits 4:1 gives one tick every 2^(N+1) clocks. With it clear, every enabled clock is a tick.
- R9: A change of the clock-control field while counting restarts the prescale period. The edge that sees the change is clock 1 of the new period, so the next tick falls 2^(N+1) edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkCtrl | input | 5 | Bit 0 prescaler enable, bits 4:1 prescale exponent N |
| cntCtrl | input | 5 | Bit 0 disable, bit 1 interval mode, bit 2 down, bit 3 match enable, bit 4 clear |
| intervalVal | input | 16 | Top of the range in interval mode |
| matchVal | input | 48 | Three packed 16-bit match values, value i in bits 16i+15:16i |
| count | output | 16 | Current count |
| evInterval | output | 1 | Wrap pulse in interval mode |
| evOverflow | output | 1 | Wrap pulse in free-running mode |
| evMatch | output | 3 | Per-comparator match pulses |

## Verification
The count and every event pulse are registered together. Both are due on the first clock edge after a tick that the current inputs allow, so each result is one edge after the stimulus. Inputs change on falling edges. Outputs are sampled on the next falling edge, so after k rising edges the bench expects the count to have taken k unprescaled steps. In each table run the bench tallies the event pulses once per falling edge, and compares the tally and the final count with values computed by hand from the requirements. The prescaler restart is checked one edge before and on the edge where the first tick of the new period is due.

// File: rtl/pit_match_timer_pkg.sv
package pit_match_timer_pkg;

  typedef struct packed {
    logic tick;
    logic clear;
    logic down;
    logic ivlMode;
    logic matchEn;
  } ctr_strobe_t;

endpackage

// File: rtl/pit_match_timer_ctrl.sv
module pit_match_timer_ctrl
  import pit_match_timer_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PS_W:0]    clkCtrl,
  input  logic [4:0]       cntCtrl,
  output ctr_strobe_t      strobe
);

  localparam int DIV_W = 1 << PS_W;

  logic [PS_W:0]    clkPrev;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic [DIV_W:0]   divPeriod;
  logic             psEn;
  logic             runEn;
  logic             psChanged;

  assign psEn      = clkCtrl[0];
  assign runEn     = !cntCtrl[0] && !cntCtrl[4];
  assign psChanged = (clkCtrl != clkPrev);

  always_comb begin
    divPeriod = (DIV_W+1)'(1) << (int'(clkCtrl[PS_W:1]) + 1);
    divLimit  = divPeriod[DIV_W-1:0] - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev <= '0;
      divCnt  <= '0;
    end else begin
      clkPrev <= clkCtrl;
      if (!runEn || !psEn)      divCnt <= '0;
      else if (psChanged)       divCnt <= DIV_W'(1);
      else if (divCnt == divLimit) divCnt <= '0;
      else                      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strobe.tick    = runEn && (!psEn || (!psChanged && divCnt == divLimit));
    strobe.clear   = cntCtrl[4];
    strobe.down    = cntCtrl[2];
    strobe.ivlMode = cntCtrl[1];
    strobe.matchEn = cntCtrl[3];
  end

endmodule

// File: rtl/pit_match_timer_dp.sv
module pit_match_timer_dp
  import pit_match_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctr_strobe_t              strobe,
  input  logic [CNT_W-1:0]         intervalVal,
  input  logic [N_MATCH*CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0]         count,
  output logic                     evInterval,
  output logic                     evOverflow,
  output logic [N_MATCH-1:0]       evMatch
);

  logic [CNT_W-1:0]   topVal;
  logic [CNT_W-1:0]   nextVal;
  logic               atEdge;
  logic [N_MATCH-1:0] matchHit;

  always_comb begin
    topVal = strobe.ivlMode ? intervalVal : '1;
    if (strobe.down) begin
      atEdge  = (count == '0);
      nextVal = atEdge ? topVal : count - CNT_W'(1);
    end else begin
      atEdge  = (count >= topVal);
      nextVal = atEdge ? '0 : count + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
    logic [CNT_W-1:0] mv;
    assign mv = matchVal[i*CNT_W +: CNT_W];
    assign matchHit[i] = strobe.matchEn && (mv <= topVal) && (mv == nextVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      evInterval <= 1'b0;
      evOverflow <= 1'b0;
      evMatch    <= '0;
    end else begin
      evInterval <= 1'b0;
      evOverflow <= 1'b0;
      evMatch    <= '0;
      if (strobe.clear) begin
        count <= '0;
      end else if (strobe.tick) begin
        count      <= nextVal;
        evInterval <= atEdge && strobe.ivlMode;
        evOverflow <= atEdge && !strobe.ivlMode;
        evMatch    <= matchHit;
      end
    end
  end

endmodule

// File: rtl/pit_match_timer.sv
module pit_match_timer
  import pit_match_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3,
  parameter int PS_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PS_W:0]            clkCtrl,
  input  logic [4:0]               cntCtrl,
  input  logic [CNT_W-1:0]         intervalVal,
  input  logic [N_MATCH*CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0]         count,
  output logic                     evInterval,
  output logic                     evOverflow,
  output logic [N_MATCH-1:0]       evMatch
);

  ctr_strobe_t strobe;

  pit_match_timer_ctrl #(.PS_W(PS_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkCtrl (clkCtrl),
    .cntCtrl (cntCtrl),
    .strobe  (strobe)
  );

  pit_match_timer_dp #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .intervalVal (intervalVal),
    .matchVal    (matchVal),
    .count       (count),
    .evInterval  (evInterval),
    .evOverflow  (evOverflow),
    .evMatch     (evMatch)
  );

endmodule

// File: rtl/pit_match_timer_chk.sv
module pit_match_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [4:0]               cntCtrl,
  input logic [N_MATCH*CNT_W-1:0] matchVal,
  input logic [CNT_W-1:0]         count,
  input logic                     evInterval,
  input logic                     evOverflow,
  input logic [N_MATCH-1:0]       evMatch
);

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntCtrl[0] && !cntCtrl[4]) |=> (count == $past(count)));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntCtrl[4] |=> (count == '0 && !evInterval && !evOverflow && evMatch == '0));

  p_one_wrap_kind_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(evInterval && evOverflow));

  p_ivl_needs_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    evInterval |-> $past(cntCtrl[1]));

  p_ovf_needs_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    evOverflow |-> !$past(cntCtrl[1]));

  p_up_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((evInterval || evOverflow) && !$past(cntCtrl[2])) |-> (count == '0));

  p_down_free_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evOverflow && $past(cntCtrl[2])) |-> (count == '1));

  p_match_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evMatch != '0) |-> $past(cntCtrl[3]));

  for (genvar i = 0; i < N_MATCH; i++) begin : g_mchk
    p_match_value_r6: assert property (@(posedge clk) disable iff (!rstN)
      evMatch[i] |-> (count == $past(matchVal[i*CNT_W +: CNT_W])));
  end

endmodule

bind pit_match_timer pit_match_timer_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (.*);

// File: tb/pit_match_timer_tb.sv
module pit_match_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  clkCtrl = '0;
  logic [4:0]  cntCtrl = 5'h01;
  logic [15:0] intervalVal = '0;
  logic [47:0] matchVal = '0;
  logic [15:0] count;
  logic        evInterval, evOverflow;
  logic [2:0]  evMatch;

  int nTests = 0;
  int nFail  = 0;
  int tIvl, tOvf, tM0, tM1, tM2;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pit_match_timer u_dut (
    .clk(clk), .rstN(rstN), .clkCtrl(clkCtrl), .cntCtrl(cntCtrl),
    .intervalVal(intervalVal), .matchVal(matchVal), .count(count),
    .evInterval(evInterval), .evOverflow(evOverflow), .evMatch(evMatch)
  );

  typedef struct packed {
    logic [4:0]  ck;
    logic [4:0]  ct;
    logic [15:0] ivl;
    logic [15:0] m0, m1, m2;
    logic [31:0] cyc;
    logic [15:0] eCnt;
    logic [7:0]  eIvl, eOvf, eM0, eM1, eM2;
  } vec_t;

  // control bits: 0 disable, 1 interval, 2 down, 3 match enable
  localparam vec_t VECS [8] = '{
    '{5'h00, 5'h08, 16'd5, 16'd3,      16'd7, 16'd20,     32'd10, 16'd10,     8'd0, 8'd0, 8'd1, 8'd1, 8'd0}, // R3 R6 free up
    '{5'h00, 5'h0A, 16'd4, 16'd2,      16'd4, 16'd9,      32'd12, 16'd2,      8'd2, 8'd0, 8'd3, 8'd2, 8'd0}, // R3 R5 R6 interval up
    '{5'h00, 5'h0E, 16'd4, 16'd0,      16'd4, 16'd3,      32'd7,  16'd3,      8'd2, 8'd0, 8'd1, 8'd2, 8'd2}, // R4 interval down
    '{5'h00, 5'h0C, 16'd9, 16'hFFFE,   16'd0, 16'hFFFF,   32'd3,  16'hFFFD,   8'd0, 8'd1, 8'd1, 8'd0, 8'd1}, // R4 free down
    '{5'h03, 5'h08, 16'd0, 16'd2,      16'd1, 16'd0,      32'd10, 16'd2,      8'd0, 8'd0, 8'd1, 8'd1, 8'd0}, // R8 N=1
    '{5'h01, 5'h0A, 16'd1, 16'd1,      16'd0, 16'd2,      32'd9,  16'd0,      8'd2, 8'd0, 8'd2, 8'd2, 8'd0}, // R8 N=0 interval
    '{5'h00, 5'h02, 16'd2, 16'd1,      16'd2, 16'd0,      32'd6,  16'd0,      8'd2, 8'd0, 8'd0, 8'd0, 8'd0}, // R6 match disabled
    '{5'h00, 5'h09, 16'd3, 16'd1,      16'd2, 16'd3,      32'd5,  16'd0,      8'd0, 8'd0, 8'd0, 8'd0, 8'd0}  // R2 disabled
  };

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearTally();
    tIvl = 0; tOvf = 0; tM0 = 0; tM1 = 0; tM2 = 0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      tIvl += int'(evInterval);
      tOvf += int'(evOverflow);
      tM0  += int'(evMatch[0]);
      tM1  += int'(evMatch[1]);
      tM2  += int'(evMatch[2]);
    end
  endtask

  task automatic prep(logic [4:0] ck, logic [15:0] iv, logic [15:0] a, logic [15:0] b, logic [15:0] c);
    cntCtrl = 5'h11;
    clkCtrl = ck;
    intervalVal = iv;
    matchVal = {c, b, a};
    run(2);
    clearTally();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count in reset", int'(count), 0);
    check("R1 events in reset", int'({evInterval, evOverflow, evMatch}), 0);
    rstN = 1'b1;
    run(1);
    check("R1 count after reset", int'(count), 0);

    foreach (VECS[v]) begin
      prep(VECS[v].ck, VECS[v].ivl, VECS[v].m0, VECS[v].m1, VECS[v].m2);
      cntCtrl = VECS[v].ct;
      run(int'(VECS[v].cyc));
      check($sformatf("R3/R4/R8 vec%0d count", v), int'(count), int'(VECS[v].eCnt));
      check($sformatf("R5 vec%0d interval events", v), tIvl, int'(VECS[v].eIvl));
      check($sformatf("R5 vec%0d overflow events", v), tOvf, int'(VECS[v].eOvf));
      check($sformatf("R6 vec%0d match0", v), tM0, int'(VECS[v].eM0));
      check($sformatf("R6 vec%0d match1", v), tM1, int'(VECS[v].eM1));
      check($sformatf("R6 vec%0d match2", v), tM2, int'(VECS[v].eM2));
    end

    // R2 hold while disabled, then resume
    prep(5'h00, 16'd0, 16'd0, 16'd0, 16'd0);
    cntCtrl = 5'h00;
    run(5);
    check("R2 count before hold", int'(count), 5);
    cntCtrl = 5'h09;
    run(4);
    check("R2 count held", int'(count), 5);
    check("R2 no events while held", tOvf + tM0 + tM1 + tM2, 0);
    cntCtrl = 5'h00;
    run(2);
    check("R2 resumed count", int'(count), 7);

    // R7 clear while counting
    cntCtrl = 5'h18;
    clearTally();
    run(1);
    check("R7 clear gives zero", int'(count), 0);
    check("R7 clear raises no event", tM0 + tIvl + tOvf, 0);
    cntCtrl = 5'h08;
    run(3);
    check("R7 count after clear", int'(count), 3);

    // R3 R5 R6 full-range overflow in free mode
    prep(5'h00, 16'd7, 16'd0, 16'hFFFF, 16'd9);
    cntCtrl = 5'h08;
    run(65537);
    check("R3 free wrap count", int'(count), 1);
    check("R5 free wrap overflow", tOvf, 1);
    check("R5 no interval in free mode", tIvl, 0);
    check("R6 match at zero", tM0, 1);
    check("R6 match at top", tM1, 1);

    // R9 prescaler restart on change
    prep(5'h03, 16'd0, 16'd0, 16'd0, 16'd0);
    cntCtrl = 5'h00;
    run(3);
    check("R9 no tick yet", int'(count), 0);
    clkCtrl = 5'h05; // N=2, period 8
    run(7);
    check("R9 no tick before restarted period", int'(count), 0);
    run(1);
    check("R9 tick at end of restarted period", int'(count), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule